// File: doc/BRIEF.md
# Variable-Latency Asynchronous Peripheral Burst Master

This block is a bus-master sequencer for a slow asynchronous peripheral that sits behind a chip select. A client hands it one request at a time. The request carries a start word address, a direction, a burst length of one to four words, the write byte enables and the write words. The block then produces the strobe pattern on the peripheral pins: an active-low chip select, a read strobe, a write strobe, active-low byte selects, a read/not-write level, a byte address whose two low bits stay zero, and a 32-bit data bus split into output, output-enable and input.

The peripheral stretches each beat by holding `ready_i` low. Three programmable cycle counts shape the timing:

- the nominal strobe-low length, `cfg_strobe_i`, giving `cfg_strobe_i`+1 cycles;
- the strobe-high gap between beats, `cfg_gap_i`, giving `cfg_gap_i`+1 cycles;
- the chip-select recovery after a burst, `cfg_recov_i`, giving `cfg_recov_i`+1 cycles.

All three are captured when a request is accepted. Read words are handed back one per beat through a valid pulse. A done pulse marks the close of each burst.

Top module: `aio_burst_master`

## Requirements
- R1: After reset, `cs_n_o`, `oe_n_o` and `we_n_o` are 1, `bs_n_o` is 4'b1111, and `busy_o`, `done_o`, `bus_doe_o` and `rd_valid_o` are 0.
- R2: A request (`req_i`=1) is accepted only in a cycle where `busy_o` is 0. A request raised while `busy_o` is 1 has no effect, and `busy_o` falls to 0 exactly when recovery ends. While `busy_o` is 0, chip select and both strobes stay high and the data bus is not driven.
- R3: In the cycle after acceptance, chip select is still high and the address and direction already show the request's values. Chip select then stays low for exactly two cycles before the first strobe goes low. A strobe is never low while chip select is high.
- R4: Each beat's strobe is low for `cfg_strobe_i`+1 cycles plus one cycle for every cycle from the last nominal cycle onward in which `ready_i` is 0. `ready_i` is ignored before the last nominal cycle. The timing fields are used as captured at acceptance, and later changes to them have no effect on the running burst.
- R5: Between two beats of one burst, the strobe stays high for exactly `cfg_gap_i`+1 cycles while chip select stays low.
- R6: `bus_addr_o` is the byte address, with bits [1:0] always 00. Beat k (counting from 0) presents word address start+k (modulo 2^AW). The address never changes while a strobe stays low, and it moves to the next word only at the end of the gap.
- R7: After the last beat's strobe rises, chip select and byte selects stay asserted for exactly one cycle, and `done_o` is 1 in that cycle only.
- R8: Chip select then stays high with `busy_o`=1 for exactly `cfg_recov_i`+1 cycles.
- R9: A read (`req_write_i`=0) uses `oe_n_o` as the strobe, with `rnw_o`=1 and `bs_n_o`=4'b0000 while chip select is low. The bus input is latched at the clock edge that ends the beat's strobe. It appears on `rd_data_o`, with its beat index on `rd_beat_o`, during the single following cycle in which `rd_valid_o` is 1.
- R10: A write (`req_write_i`=1) uses `we_n_o` as the strobe, with `rnw_o`=0 and `bs_n_o`=~`req_be_i` while chip select is low. `bus_doe_o` is 1 from the cycle after acceptance until the last strobe rises. `bus_dout_o` carries word k during beat k's strobe, where word k is `req_wdata_i[32k+31:32k]`.
- R11: `rnw_o` takes its value in the cycle after acceptance and stays stable for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request, taken when busy_o is 0 |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | 24 | Start word address |
| req_len_i | input | 2 | Number of beats minus one |
| req_be_i | input | 4 | Write byte enables, active high |
| req_wdata_i | input | 128 | Write words, word k in bits [32k+31:32k] |
| cfg_strobe_i | input | 5 | Strobe-low cycles minus one |
| cfg_gap_i | input | 5 | Inter-beat strobe-high cycles minus one |
| cfg_recov_i | input | 5 | Chip-select recovery cycles minus one |
| ready_i | input | 1 | Peripheral ready; low stretches the strobe |
| busy_o | output | 1 | Burst or recovery in progress |
| done_o | output | 1 | One-cycle pulse at the end of a burst |
| rd_valid_o | output | 1 | Read word valid pulse |
| rd_beat_o | output | 2 | Beat index of rd_data_o |
| rd_data_o | output | 32 | Latched read word |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| bs_n_o | output | 4 | Byte selects, active low |
| rnw_o | output | 1 | Direction, 1 = read |
| bus_addr_o | output | 26 | Byte address, bits [1:0] zero |
| bus_dout_o | output | 32 | Write data toward the bus |
| bus_doe_o | output | 1 | Drive enable for bus_dout_o |
| bus_din_i | input | 32 | Read data from the bus |

## Verification
Every cycle, the assertions check the relations between pins that must always hold:

- a strobe is only ever low inside a low chip select;
- there are two chip-select cycles ahead of each first strobe, and a tail cycle after the last;
- the address and direction stay frozen across strobes and chip-select edges;
- the read byte selects and the write drive enable match the direction;
- `done_o` lasts one cycle, and the pins are quiet while idle.

Exact cycle counts can only be shown by the bench's scenarios, which check each pin cycle by cycle against a timeline built from the captured settings and the wait pattern it applies. Those counts are the strobe length with waits, the gap length, the recovery length, the per-beat address steps, the read word sampled at the edge that ends the strobe, the write word per beat, and the rejection of requests raised during recovery.

// File: rtl/aio_pkg.sv
package aio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CSLEAD,
        ST_STROBE,
        ST_GAP,
        ST_HOLD,
        ST_RECOV
    } aio_state_e;

endpackage

// File: rtl/aio_cycle_timer.sv
// Loadable down-counter; holds at zero until reloaded.
module aio_cycle_timer #(
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/aio_beat_addr.sv
// Word address and beat index of the running burst.
module aio_beat_addr #(
    parameter int AW = 24,
    parameter int BW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [BW-1:0] beat_o
);

    logic [AW-1:0] addr_d, addr_q;
    logic [BW-1:0] beat_d, beat_q;

    always_comb begin
        addr_d = addr_q;
        beat_d = beat_q;
        if (load_i) begin
            addr_d = base_i;
            beat_d = '0;
        end else if (step_i) begin
            addr_d = addr_q + 1'b1;
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
            beat_q <= '0;
        end else begin
            addr_q <= addr_d;
            beat_q <= beat_d;
        end
    end

    assign addr_o = addr_q;
    assign beat_o = beat_q;

endmodule

// File: rtl/aio_wdata_bank.sv
// Holds the write words of one burst and selects the current beat's word.
module aio_wdata_bank #(
    parameter int DW = 32,
    parameter int NW = 4,
    parameter int SW = $clog2(NW)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           capture_i,
    input  logic [NW*DW-1:0] words_i,
    input  logic [SW-1:0]  sel_i,
    output logic [DW-1:0]  word_o
);

    logic [DW-1:0] word_q [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [DW-1:0] word_d;

        always_comb begin
            word_d = capture_i ? words_i[g*DW +: DW] : word_q[g];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) word_q[g] <= '0;
            else         word_q[g] <= word_d;
        end
    end

    assign word_o = word_q[sel_i];

endmodule

// File: rtl/aio_burst_master.sv
module aio_burst_master
    import aio_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 4,
    parameter int CW        = 5,
    localparam int BW  = $clog2(MAX_BEATS),
    localparam int SW  = DW / 8,
    localparam int LSB = $clog2(SW)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    req_write_i,
    input  logic [AW-1:0]           req_addr_i,
    input  logic [BW-1:0]           req_len_i,
    input  logic [SW-1:0]           req_be_i,
    input  logic [MAX_BEATS*DW-1:0] req_wdata_i,
    input  logic [CW-1:0]           cfg_strobe_i,
    input  logic [CW-1:0]           cfg_gap_i,
    input  logic [CW-1:0]           cfg_recov_i,
    input  logic                    ready_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    rd_valid_o,
    output logic [BW-1:0]           rd_beat_o,
    output logic [DW-1:0]           rd_data_o,
    output logic                    cs_n_o,
    output logic                    oe_n_o,
    output logic                    we_n_o,
    output logic [SW-1:0]           bs_n_o,
    output logic                    rnw_o,
    output logic [AW+LSB-1:0]       bus_addr_o,
    output logic [DW-1:0]           bus_dout_o,
    output logic                    bus_doe_o,
    input  logic [DW-1:0]           bus_din_i
);

    typedef struct packed {
        aio_state_e    state;
        logic          rnw;
        logic [BW-1:0] len;
        logic [SW-1:0] be;
        logic [CW-1:0] t_strobe;
        logic [CW-1:0] t_gap;
        logic [CW-1:0] t_recov;
        logic          rd_valid;
        logic [BW-1:0] rd_beat;
        logic [DW-1:0] rd_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          adr_load;
    logic          adr_step;
    logic [AW-1:0] word_addr;
    logic [BW-1:0] beat;
    logic [DW-1:0] cur_word;
    logic          cs_act;

    aio_cycle_timer #(.CW(CW)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    aio_beat_addr #(.AW(AW), .BW(BW)) u_addr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (adr_load),
        .base_i (req_addr_i),
        .step_i (adr_step),
        .addr_o (word_addr),
        .beat_o (beat)
    );

    aio_wdata_bank #(.DW(DW), .NW(MAX_BEATS), .SW(BW)) u_wbank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (adr_load),
        .words_i   (req_wdata_i),
        .sel_i     (beat),
        .word_o    (cur_word)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        adr_load       = 1'b0;
        adr_step       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.state    = ST_SETUP;
                    ctl_d.rnw      = ~req_write_i;
                    ctl_d.len      = req_len_i;
                    ctl_d.be       = req_be_i;
                    ctl_d.t_strobe = cfg_strobe_i;
                    ctl_d.t_gap    = cfg_gap_i;
                    ctl_d.t_recov  = cfg_recov_i;
                    adr_load       = 1'b1;
                end
            end
            ST_SETUP: begin
                // address and direction settle with chip select still high
                ctl_d.state = ST_CSLEAD;
                tmr_load    = 1'b1;
                tmr_val     = CW'(1);
            end
            ST_CSLEAD: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_STROBE;
                    tmr_load    = 1'b1;
                    tmr_val     = ctl_q.t_strobe;
                end
            end
            ST_STROBE: begin
                // last nominal cycle reached: wait for the peripheral
                if (tmr_zero && ready_i) begin
                    if (ctl_q.rnw) begin
                        ctl_d.rd_valid = 1'b1;
                        ctl_d.rd_data  = bus_din_i;
                        ctl_d.rd_beat  = beat;
                    end
                    if (beat == ctl_q.len) begin
                        ctl_d.state = ST_HOLD;
                    end else begin
                        ctl_d.state = ST_GAP;
                        tmr_load    = 1'b1;
                        tmr_val     = ctl_q.t_gap;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_STROBE;
                    tmr_load    = 1'b1;
                    tmr_val     = ctl_q.t_strobe;
                    adr_step    = 1'b1;
                end
            end
            ST_HOLD: begin
                ctl_d.state = ST_RECOV;
                tmr_load    = 1'b1;
                tmr_val     = ctl_q.t_recov;
            end
            ST_RECOV: begin
                if (tmr_zero) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.rnw   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_act = (ctl_q.state == ST_CSLEAD) || (ctl_q.state == ST_STROBE) ||
                    (ctl_q.state == ST_GAP)    || (ctl_q.state == ST_HOLD);

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign done_o     = (ctl_q.state == ST_HOLD);
    assign rd_valid_o = ctl_q.rd_valid;
    assign rd_beat_o  = ctl_q.rd_beat;
    assign rd_data_o  = ctl_q.rd_data;
    assign cs_n_o     = ~cs_act;
    assign oe_n_o     = ~((ctl_q.state == ST_STROBE) && ctl_q.rnw);
    assign we_n_o     = ~((ctl_q.state == ST_STROBE) && !ctl_q.rnw);
    assign bs_n_o     = !cs_act ? '1 : (ctl_q.rnw ? '0 : ~ctl_q.be);
    assign rnw_o      = ctl_q.rnw;
    assign bus_addr_o = {word_addr, {LSB{1'b0}}};
    assign bus_dout_o = cur_word;
    assign bus_doe_o  = !ctl_q.rnw &&
                        ((ctl_q.state == ST_SETUP) || (ctl_q.state == ST_CSLEAD) ||
                         (ctl_q.state == ST_STROBE) || (ctl_q.state == ST_GAP));

endmodule

// File: rtl/aio_burst_master_chk.sv
module aio_burst_master_chk #(
    parameter int AW  = 24,
    parameter int SW  = 4,
    parameter int LSB = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_n_o,
    input logic              oe_n_o,
    input logic              we_n_o,
    input logic [SW-1:0]     bs_n_o,
    input logic              rnw_o,
    input logic [AW+LSB-1:0] bus_addr_o,
    input logic              bus_doe_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              rd_valid_o
);

    logic strb_n;
    assign strb_n = oe_n_o & we_n_o;

    AST_ADDR_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_o[LSB-1:0] == '0); // R6
    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_n_o || we_n_o); // R4
    AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strb_n |-> !cs_n_o); // R3
    AST_CS_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(strb_n) |-> ($past(!cs_n_o) && $past(!cs_n_o, 2))); // R3
    AST_ADDR_BEFORE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_n_o) |-> ($stable(bus_addr_o) && $stable(rnw_o))); // R3
    AST_ADDR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strb_n && $past(!strb_n)) |-> $stable(bus_addr_o)); // R6
    AST_CS_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(strb_n) |-> !cs_n_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_DONE_IN_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!cs_n_o && strb_n)); // R7
    AST_RECOV_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_n_o) |-> busy_o); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (cs_n_o && strb_n && !bus_doe_o)); // R2
    AST_READ_BS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_o && rnw_o) |-> (bs_n_o == '0)); // R9
    AST_OE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_n_o |-> rnw_o); // R9
    AST_RDV_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> rnw_o); // R9
    AST_WE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_o |-> !rnw_o); // R10
    AST_DOE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_doe_o |-> !rnw_o); // R10
    AST_RNW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_o && $past(!cs_n_o)) |-> $stable(rnw_o)); // R11

endmodule

bind aio_burst_master aio_burst_master_chk #(.AW(AW), .SW(SW), .LSB(LSB)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_o     (cs_n_o),
    .oe_n_o     (oe_n_o),
    .we_n_o     (we_n_o),
    .bs_n_o     (bs_n_o),
    .rnw_o      (rnw_o),
    .bus_addr_o (bus_addr_o),
    .bus_doe_o  (bus_doe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_valid_o (rd_valid_o)
);

// File: tb/aio_burst_master_tb_top.sv
module aio_burst_master_tb_top;

    localparam int AW = 24;
    localparam int WATCHDOG = 150000;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          req_i = 1'b0;
    logic          req_write_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [1:0]    req_len_i = '0;
    logic [3:0]    req_be_i = '0;
    logic [127:0]  req_wdata_i = '0;
    logic [4:0]    cfg_strobe_i = '0;
    logic [4:0]    cfg_gap_i = '0;
    logic [4:0]    cfg_recov_i = '0;
    logic          ready_i = 1'b0;
    logic          busy_o, done_o, rd_valid_o;
    logic [1:0]    rd_beat_o;
    logic [31:0]   rd_data_o;
    logic          cs_n_o, oe_n_o, we_n_o;
    logic [3:0]    bs_n_o;
    logic          rnw_o;
    logic [AW+1:0] bus_addr_o;
    logic [31:0]   bus_dout_o;
    logic          bus_doe_o;
    logic [31:0]   bus_din_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int wt [4];
    logic [31:0] wd [4];

    always #5 clk_i = ~clk_i;

    aio_burst_master dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_be_i(req_be_i),
        .req_wdata_i(req_wdata_i), .cfg_strobe_i(cfg_strobe_i), .cfg_gap_i(cfg_gap_i),
        .cfg_recov_i(cfg_recov_i), .ready_i(ready_i), .busy_o(busy_o), .done_o(done_o),
        .rd_valid_o(rd_valid_o), .rd_beat_o(rd_beat_o), .rd_data_o(rd_data_o),
        .cs_n_o(cs_n_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o), .bs_n_o(bs_n_o),
        .rnw_o(rnw_o), .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o),
        .bus_doe_o(bus_doe_o), .bus_din_i(bus_din_i)
    );

    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=%0d cycles", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s at cycle %0d: act=%0h exp=%0h", rq, what, cyc, act, exp);
        end
    endtask

    // pins packed as {cs,oe,we,bs[3:0],busy,done,doe,rdv}
    task automatic exp_pins(string rq, logic ecs, logic eoe, logic ewe, logic [3:0] ebs,
                            logic ebusy, logic edone, logic edoe, logic erdv);
        chk(rq, "pins{cs,oe,we,bs,busy,done,doe,rdv}",
            64'({cs_n_o, oe_n_o, we_n_o, bs_n_o, busy_o, done_o, bus_doe_o, rd_valid_o}),
            64'({ecs, eoe, ewe, ebs, ebusy, edone, edoe, erdv}));
    endtask

    // Runs one burst from an idle negedge and returns at the idle negedge after it.
    task automatic run_burst(bit wr, int len, logic [AW-1:0] base, logic [3:0] be,
                             int rdf, int rdn, int rrr);
        logic [3:0]  ebs;
        logic [31:0] rdexp;
        logic        eoe, ewe;
        ebs = wr ? ~be : 4'h0;
        eoe = wr ? 1'b1 : 1'b0;
        ewe = wr ? 1'b0 : 1'b1;
        rdexp = '0;
        req_i        = 1'b1;
        req_write_i  = wr;
        req_addr_i   = base;
        req_len_i    = 2'(len - 1);
        req_be_i     = be;
        req_wdata_i  = {wd[3], wd[2], wd[1], wd[0]};
        cfg_strobe_i = 5'(rdf);
        cfg_gap_i    = 5'(rdn);
        cfg_recov_i  = 5'(rrr);
        @(negedge clk_i);
        // setup cycle; scramble settings to show they were captured (R4)
        req_i        = 1'b0;
        cfg_strobe_i = 5'($urandom);
        cfg_gap_i    = 5'($urandom);
        cfg_recov_i  = 5'($urandom);
        exp_pins("R3", 1, 1, 1, 4'hf, 1, 0, wr, 0);
        chk("R3", "setup address", 64'(bus_addr_o), 64'({base, 2'b00}));
        chk("R11", "setup rnw", 64'(rnw_o), 64'(!wr));
        for (int c = 0; c < 2; c++) begin
            @(negedge clk_i);
            exp_pins("R3", 0, 1, 1, ebs, 1, 0, wr, 0);
        end
        for (int b = 0; b < len; b++) begin
            for (int i = 0; i <= rdf + wt[b]; i++) begin
                @(negedge clk_i);
                exp_pins("R4", 0, eoe, ewe, ebs, 1, 0, wr, 0);
                chk("R6", "strobe address", 64'(bus_addr_o), 64'({base + AW'(b), 2'b00}));
                chk("R11", "rnw in burst", 64'(rnw_o), 64'(!wr));
                if (wr) chk("R10", "write word", 64'(bus_dout_o), 64'(wd[b]));
                ready_i   = (i < rdf) ? 1'($urandom) : (i >= rdf + wt[b]);
                bus_din_i = $urandom;
                rdexp     = bus_din_i;
            end
            if (b < len - 1) begin
                for (int j = 0; j <= rdn; j++) begin
                    @(negedge clk_i);
                    exp_pins("R5", 0, 1, 1, ebs, 1, 0, wr, (!wr && j == 0));
                    chk("R6", "gap address", 64'(bus_addr_o), 64'({base + AW'(b), 2'b00}));
                    if (!wr && j == 0) begin
                        chk("R9", "read word", 64'(rd_data_o), 64'(rdexp));
                        chk("R9", "read beat", 64'(rd_beat_o), 64'(b));
                    end
                    ready_i   = 1'($urandom);
                    bus_din_i = $urandom;
                end
            end else begin
                @(negedge clk_i);
                exp_pins("R7", 0, 1, 1, ebs, 1, 1, 0, !wr);
                if (!wr) begin
                    chk("R9", "last read word", 64'(rd_data_o), 64'(rdexp));
                    chk("R9", "last read beat", 64'(rd_beat_o), 64'(b));
                end
            end
        end
        for (int k = 0; k <= rrr; k++) begin
            @(negedge clk_i);
            exp_pins("R8", 1, 1, 1, 4'hf, 1, 0, 0, 0);
            // request raised during recovery must be ignored (R2)
            req_i       = (k < rrr);
            req_addr_i  = AW'($urandom);
            req_write_i = 1'($urandom);
        end
        @(negedge clk_i);
        req_i = 1'b0;
        exp_pins("R2", 1, 1, 1, 4'hf, 0, 0, 0, 0);
    endtask

    task automatic fill_words();
        for (int i = 0; i < 4; i++) wd[i] = $urandom;
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        exp_pins("R1", 1, 1, 1, 4'hf, 0, 0, 0, 0);

        // directed: read burst of four, one wait cycle per beat
        for (int i = 0; i < 4; i++) wt[i] = 1;
        run_burst(0, 4, 24'h000100, 4'hf, 1, 0, 0);
        // directed: minimal-timing write burst of four
        for (int i = 0; i < 4; i++) wt[i] = 0;
        fill_words();
        run_burst(1, 4, 24'h0000fe, 4'hf, 0, 0, 0);
        // directed: address wrap and partial byte enables
        fill_words();
        run_burst(1, 3, 24'hfffffe, 4'b0101, 2, 1, 2);
        // directed: single read with maximum settings
        wt[0] = 2;
        run_burst(0, 1, 24'h123456, 4'hf, 31, 31, 31);
        // directed: single write with maximum settings
        fill_words();
        wt[0] = 0;
        run_burst(1, 1, 24'h000000, 4'b1000, 31, 31, 31);

        // constrained random bursts
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 4; i++) wt[i] = $urandom_range(0, 3);
            fill_words();
            run_burst(1'($urandom), $urandom_range(1, 4), AW'($urandom), 4'($urandom),
                      $urandom_range(0, 6), $urandom_range(0, 4), $urandom_range(0, 4));
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk_i);
                exp_pins("R2", 1, 1, 1, 4'hf, 0, 0, 0, 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule